// File: doc/BRIEF.md
# Multiplexed External Memory Bus Port Controller

This block lets a microcontroller core reach external program and data memory through two 8-bit general-purpose ports. The low port and the high port double as a time-multiplexed address/data bus. The core hands the block one request at a time: an instruction fetch, a data read or a data write, with an address of up to 18 bits. The block runs a fixed bus cycle. First comes an address phase with ALE high. Then a strobe phase with exactly one active-low strobe asserted. Last comes a one-cycle closing phase that pulses `done`. Read data is captured at the edge where the strobe returns high.

Two bus modes are supported, chosen per request. In nonpage mode the low port carries the low address byte and then the data, and the high port carries the upper address byte. In page mode the low port holds the low address byte for the whole cycle, and the high port carries the upper address byte and then the data. Address bits 17:16 appear on two dedicated pins. Bits above the configured address width are forced to zero.

The block also owns the two port output latches that software writes. Every accepted bus cycle overwrites the low latch with all ones. The high latch is never touched by bus cycles, and it reappears on the high pins whenever the bus is not using them. Only the logical output value, output enable and tri-state are modelled.

Top module: `xbp_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes idle. `busy`, `done` and `ale` are 0, `psen_n`, `rd_n` and `wr_n` are 1, both port latches read 8'hFF, `rsp_rdata` is 0 and `ahi_out` is 0.
- R2: A request (`req_valid` high while `busy` is low) starts a cycle at the next edge. The cycle has one cycle with `ale`=1, then STB_CYC strobe cycles, then one cycle with `done`=1. `busy` is high across all of them. `req_valid` seen while `busy` is high has no effect.
- R3: Each accepted request loads 8'hFF into the low port latch at the accepting edge. This wins over a software write in the same cycle.
- R4: Bus cycles never change the high port latch. Whenever the high pins carry neither address nor data, they drive the high latch value with `hi_oe`=1.
- R5: Nonpage mode (`req_page`=0). During the ALE cycle the low pins drive addr[7:0]. During the strobe cycles the low pins drive the write data, or are tri-stated (`lo_oe`=0) for a fetch or read. The high pins drive addr[15:8] in both phases.
- R6: Page mode (`req_page`=1). The low pins drive addr[7:0] in both the ALE and strobe phases. The high pins drive addr[15:8] during ALE. During the strobe cycles they drive the write data, or are tri-stated for a fetch or read.
- R7: `req_kind` is 2'b00 fetch, 2'b10 write, 2'b01 or 2'b11 data read. A fetch strobes `psen_n`. A write strobes `wr_n`. A data read strobes `psen_n` if `cfg_rdsel`=2'b00, otherwise `rd_n`. At most one strobe is low at any time, and only in strobe cycles.
- R8: Fetch address width comes from `cfg_xaddr`: 2'b00 gives 16 bits, 2'b01 gives 17, 2'b1x gives 18. Data address width comes from `req_awidth`: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 17, 2'b11 gives 18. Bits above the width read as 0 on every pin. `ahi_out` shows addr[17:16] from the ALE cycle through the closing cycle and is 0 when idle. With an 8-bit data address the high pins show the high latch instead of an address byte.
- R9: For a fetch or read, `rsp_rdata` takes the value on `lo_in` (nonpage) or `hi_in` (page) at the edge that ends the last strobe cycle. It holds that value until the next fetch or read completes.
- R10: A software write (`sw_lo_we` / `sw_hi_we`) updates its latch at the next edge, and the value shows on the pins when the port is not in bus use. A write to the high latch during a bus cycle shows on any high pins not in use from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01/11 read, 10 write |
| req_addr | input | 18 | Request address |
| req_wdata | input | 8 | Write data |
| req_awidth | input | 2 | Data address width select |
| req_page | input | 1 | 1 = page mode for this cycle |
| cfg_xaddr | input | 2 | Fetch address width select |
| cfg_rdsel | input | 2 | Data read strobe select |
| busy | output | 1 | Bus cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read data |
| sw_lo_we | input | 1 | Software write to low latch |
| sw_lo_wdata | input | 8 | Low latch write value |
| sw_hi_we | input | 1 | Software write to high latch |
| sw_hi_wdata | input | 8 | High latch write value |
| lo_latch | output | 8 | Low latch contents |
| hi_latch | output | 8 | High latch contents |
| lo_in | input | 8 | Low port pin input |
| lo_out | output | 8 | Low port pin output value |
| lo_oe | output | 1 | Low port output enable |
| hi_in | input | 8 | High port pin input |
| hi_out | output | 8 | High port pin output value |
| hi_oe | output | 1 | High port output enable |
| ahi_out | output | 2 | Address bits 17:16 |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The hardest cases to reach from the ports are collisions in a single clock edge. One is a software write to the low latch in the exact cycle a request is accepted. Another is a high-latch write that lands in the middle of an 8-bit page-mode cycle, while the high pins are showing the latch. A third is a new request raised while the block is busy. The stimulus schedules each of these at a chosen negative edge relative to the request.

A behavioural model steps through the cycle phases and predicts every pin on each clock. The read-data input patterns change every cycle, so any capture made one edge too early or too late gives a different byte.

// File: rtl/xbp_pkg.sv
package xbp_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 18;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ALE  = 2'd1,
        PH_STB  = 2'd2,
        PH_END  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [ADDR_W-1:0]  addr;
        logic [PORT_W-1:0]  wdata;
        logic               page;
        logic               use_rd;
        logic               narrow;
    } cyc_t;

    function automatic kind_e decode_kind(input logic [1:0] code);
        if (code == 2'b00)      return K_FETCH;
        else if (code == 2'b10) return K_WRITE;
        else                    return K_READ;
    endfunction

    function automatic int unsigned addr_bits(input kind_e kind,
                                              input logic [1:0] awidth,
                                              input logic [1:0] xaddr);
        if (kind == K_FETCH) begin
            if (xaddr == 2'b00)      return 16;
            else if (xaddr == 2'b01) return 17;
            else                     return 18;
        end
        case (awidth)
            2'b00:   return 8;
            2'b01:   return 16;
            2'b10:   return 17;
            default: return 18;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] mask_addr(input logic [ADDR_W-1:0] a,
                                                    input int unsigned bits);
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) m[i] = (i < bits);
        return a & m;
    endfunction

endpackage

// File: rtl/xbp_seq.sv
module xbp_seq
    import xbp_pkg::*;
#(
    parameter int STB_CYC = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   last_stb
);
    localparam int CW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STB_CYC - 1);

    phase_e        ph_q;
    logic [CW-1:0] cnt_q;

    assign phase    = ph_q;
    assign last_stb = (ph_q == PH_STB) && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start) ph_q <= PH_ALE;
                PH_ALE: begin
                    ph_q  <= PH_STB;
                    cnt_q <= '0;
                end
                PH_STB: begin
                    if (cnt_q == LAST) ph_q <= PH_END;
                    else               cnt_q <= cnt_q + 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xbp_latch.sv
module xbp_latch
    import xbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clobber,
    input  logic              lo_we,
    input  logic [PORT_W-1:0] lo_wdata,
    input  logic              hi_we,
    input  logic [PORT_W-1:0] hi_wdata,
    output logic [PORT_W-1:0] lo_q,
    output logic [PORT_W-1:0] hi_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '1;
            hi_q <= '1;
        end else begin
            if (clobber)    lo_q <= '1;
            else if (lo_we) lo_q <= lo_wdata;
            if (hi_we)      hi_q <= hi_wdata;
        end
    end
endmodule

// File: rtl/xbp_pinmux.sv
module xbp_pinmux
    import xbp_pkg::*;
(
    input  phase_e            phase,
    input  cyc_t              cyc,
    input  logic [PORT_W-1:0] lo_q,
    input  logic [PORT_W-1:0] hi_q,
    output logic [PORT_W-1:0] lo_out,
    output logic              lo_oe,
    output logic [PORT_W-1:0] hi_out,
    output logic              hi_oe,
    output logic [1:0]        ahi_out,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n
);
    logic in_stb, is_wr;

    assign in_stb = (phase == PH_STB);
    assign is_wr  = (cyc.kind == K_WRITE);
    assign ale    = (phase == PH_ALE);

    always_comb begin
        lo_out = lo_q;
        lo_oe  = 1'b1;
        if (phase == PH_ALE) begin
            lo_out = cyc.addr[7:0];
        end else if (in_stb) begin
            if (cyc.page)  lo_out = cyc.addr[7:0];
            else if (is_wr) lo_out = cyc.wdata;
            else begin
                lo_out = '0;
                lo_oe  = 1'b0;
            end
        end
    end

    always_comb begin
        hi_out = hi_q;
        hi_oe  = 1'b1;
        if (phase == PH_ALE) begin
            if (!cyc.narrow) hi_out = cyc.addr[15:8];
        end else if (in_stb) begin
            if (cyc.page) begin
                if (is_wr) hi_out = cyc.wdata;
                else begin
                    hi_out = '0;
                    hi_oe  = 1'b0;
                end
            end else if (!cyc.narrow) begin
                hi_out = cyc.addr[15:8];
            end
        end
    end

    assign ahi_out = (phase == PH_IDLE) ? 2'b00 : cyc.addr[17:16];
    assign psen_n  = !(in_stb && ((cyc.kind == K_FETCH) ||
                                  (cyc.kind == K_READ && !cyc.use_rd)));
    assign rd_n    = !(in_stb && cyc.kind == K_READ && cyc.use_rd);
    assign wr_n    = !(in_stb && is_wr);
endmodule

// File: rtl/xbp_top.sv
module xbp_top
    import xbp_pkg::*;
#(
    parameter int STB_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [17:0] req_addr,
    input  logic [7:0]  req_wdata,
    input  logic [1:0]  req_awidth,
    input  logic        req_page,
    input  logic [1:0]  cfg_xaddr,
    input  logic [1:0]  cfg_rdsel,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rsp_rdata,
    input  logic        sw_lo_we,
    input  logic [7:0]  sw_lo_wdata,
    input  logic        sw_hi_we,
    input  logic [7:0]  sw_hi_wdata,
    output logic [7:0]  lo_latch,
    output logic [7:0]  hi_latch,
    input  logic [7:0]  lo_in,
    output logic [7:0]  lo_out,
    output logic        lo_oe,
    input  logic [7:0]  hi_in,
    output logic [7:0]  hi_out,
    output logic        hi_oe,
    output logic [1:0]  ahi_out,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n
);
    phase_e phase;
    logic   last_stb;
    logic   accept;
    cyc_t   cyc_q, cyc_d;
    kind_e  kind_in;

    assign busy    = (phase != PH_IDLE);
    assign done    = (phase == PH_END);
    assign accept  = req_valid && !busy;
    assign kind_in = decode_kind(req_kind);

    always_comb begin
        cyc_d.kind   = kind_in;
        cyc_d.addr   = mask_addr(req_addr, addr_bits(kind_in, req_awidth, cfg_xaddr));
        cyc_d.wdata  = req_wdata;
        cyc_d.page   = req_page;
        cyc_d.use_rd = (cfg_rdsel != 2'b00);
        cyc_d.narrow = (kind_in != K_FETCH) && (req_awidth == 2'b00);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q     <= '0;
            rsp_rdata <= '0;
        end else begin
            if (accept) cyc_q <= cyc_d;
            if (last_stb && cyc_q.kind != K_WRITE)
                rsp_rdata <= cyc_q.page ? hi_in : lo_in;
        end
    end

    xbp_seq #(.STB_CYC(STB_CYC)) seq_i (
        .clk(clk), .rst(rst), .start(accept),
        .phase(phase), .last_stb(last_stb)
    );

    xbp_latch latch_i (
        .clk(clk), .rst(rst), .clobber(accept),
        .lo_we(sw_lo_we), .lo_wdata(sw_lo_wdata),
        .hi_we(sw_hi_we), .hi_wdata(sw_hi_wdata),
        .lo_q(lo_latch), .hi_q(hi_latch)
    );

    xbp_pinmux pinmux_i (
        .phase(phase), .cyc(cyc_q), .lo_q(lo_latch), .hi_q(hi_latch),
        .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .hi_oe(hi_oe),
        .ahi_out(ahi_out), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );
endmodule

// File: rtl/xbp_chk.sv
module xbp_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic       ale,
    input logic       lo_oe,
    input logic       psen_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       sw_hi_we,
    input logic [7:0] lo_latch,
    input logic [7:0] hi_latch,
    input logic [1:0] ahi_out
);
    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (psen_n && rd_n && wr_n && !ale));

    assert_accept_ale_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (ale && busy));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    assert_ale_lo_driven_R5: assert property (@(posedge clk) disable iff (rst)
        ale |-> lo_oe);

    assert_lo_clobber_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (lo_latch == 8'hFF));

    assert_hi_kept_R4: assert property (@(posedge clk) disable iff (rst)
        !sw_hi_we |=> $stable(hi_latch));

    assert_ahi_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ahi_out == 2'b00));
endmodule

bind xbp_top xbp_chk chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .done(done),
    .ale(ale), .lo_oe(lo_oe), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .sw_hi_we(sw_hi_we), .lo_latch(lo_latch), .hi_latch(hi_latch),
    .ahi_out(ahi_out)
);

// File: tb/xbp_top_tb_top.sv
`timescale 1ns/1ps
module xbp_top_tb_top;
    localparam int NSTB = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic [17:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [1:0] req_awidth = 2'b00;
    logic req_page = 1'b0;
    logic [1:0] cfg_xaddr = 2'b00;
    logic [1:0] cfg_rdsel = 2'b00;
    logic sw_lo_we = 1'b0, sw_hi_we = 1'b0;
    logic [7:0] sw_lo_wdata = '0, sw_hi_wdata = '0;
    logic [7:0] lo_in = '0, hi_in = '0;
    logic busy, done, lo_oe, hi_oe, ale, psen_n, rd_n, wr_n;
    logic [7:0] rsp_rdata, lo_latch, hi_latch, lo_out, hi_out;
    logic [1:0] ahi_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xbp_top #(.STB_CYC(NSTB)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_awidth(req_awidth),
        .req_page(req_page), .cfg_xaddr(cfg_xaddr), .cfg_rdsel(cfg_rdsel),
        .busy(busy), .done(done), .rsp_rdata(rsp_rdata),
        .sw_lo_we(sw_lo_we), .sw_lo_wdata(sw_lo_wdata),
        .sw_hi_we(sw_hi_we), .sw_hi_wdata(sw_hi_wdata),
        .lo_latch(lo_latch), .hi_latch(hi_latch),
        .lo_in(lo_in), .lo_out(lo_out), .lo_oe(lo_oe),
        .hi_in(hi_in), .hi_out(hi_out), .hi_oe(hi_oe),
        .ahi_out(ahi_out), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    // reference model state
    int m_phase = 0;
    int m_kind = 0;           // 0 fetch, 1 read, 2 write
    int m_addr = 0;
    int m_wdata = 0;
    bit m_page = 0, m_use_rd = 0, m_narrow = 0;
    int m_lo = 8'hFF, m_hi = 8'hFF, m_rdata = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        lo_in <= 8'(cyc * 37 + 5);
        hi_in <= 8'(cyc * 91 + 200);
    end

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_phase = 0; m_lo = 8'hFF; m_hi = 8'hFF; m_rdata = 0; m_addr = 0;
        end else begin
            if (sw_hi_we) m_hi = sw_hi_wdata;
            if (m_phase == 0 && req_valid) begin
                int w;
                m_lo = 8'hFF;
                m_kind = (req_kind == 2'b00) ? 0 : (req_kind == 2'b10) ? 2 : 1;
                if (m_kind == 0) w = (cfg_xaddr == 0) ? 16 : (cfg_xaddr == 1) ? 17 : 18;
                else w = (req_awidth == 0) ? 8 : (req_awidth == 1) ? 16 : (req_awidth == 2) ? 17 : 18;
                m_addr = int'(req_addr) & ((1 << w) - 1);
                m_wdata = req_wdata;
                m_page = req_page;
                m_use_rd = (cfg_rdsel != 0);
                m_narrow = (m_kind != 0) && (req_awidth == 0);
                m_phase = 1;
            end else begin
                if (sw_lo_we) m_lo = sw_lo_wdata;
                if (m_phase == NSTB + 1 && m_kind != 2) m_rdata = m_page ? hi_in : lo_in;
                if (m_phase == NSTB + 2) m_phase = 0;
                else if (m_phase != 0) m_phase++;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            bit stb;
            int e_lo, e_hi;
            bit e_looe, e_hioe;
            string pt;
            stb = (m_phase >= 2 && m_phase <= NSTB + 1);
            pt = m_page ? "R6" : "R5";
            chk("R2 busy", busy, m_phase != 0);
            chk("R2 done", done, m_phase == NSTB + 2);
            chk("R2 ale", ale, m_phase == 1);
            chk("R7 psen_n", psen_n, !(stb && (m_kind == 0 || (m_kind == 1 && !m_use_rd))));
            chk("R7 rd_n", rd_n, !(stb && m_kind == 1 && m_use_rd));
            chk("R7 wr_n", wr_n, !(stb && m_kind == 2));
            chk("R8 ahi_out", ahi_out, (m_phase != 0) ? ((m_addr >> 16) & 3) : 0);
            chk("R9 rsp_rdata", rsp_rdata, m_rdata);
            chk("R3 lo_latch", lo_latch, m_lo);
            chk("R4 hi_latch", hi_latch, m_hi);
            e_looe = 1; e_lo = m_lo;
            e_hioe = 1; e_hi = m_hi;
            if (m_phase == 1) begin
                e_lo = m_addr & 8'hFF;
                if (!m_narrow) e_hi = (m_addr >> 8) & 8'hFF;
            end else if (stb) begin
                if (m_page) begin
                    e_lo = m_addr & 8'hFF;
                    if (m_kind == 2) e_hi = m_wdata; else e_hioe = 0;
                end else begin
                    if (m_kind == 2) e_lo = m_wdata; else e_looe = 0;
                    if (!m_narrow) e_hi = (m_addr >> 8) & 8'hFF;
                end
            end
            chk(m_phase == 0 ? "R10 lo_oe" : pt, lo_oe, e_looe);
            if (e_looe) chk(m_phase == 0 ? "R10 lo_out" : pt, lo_out, e_lo);
            chk(m_phase == 0 ? "R4 hi_oe" : pt, hi_oe, e_hioe);
            if (e_hioe) chk(m_narrow ? "R8 hi_out" : (m_phase == 0 ? "R4 hi_out" : pt), hi_out, e_hi);
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] k, input logic [17:0] a, input logic [7:0] wd,
                         input logic [1:0] aw, input logic pg);
        @(negedge clk);
        req_valid = 1; req_kind = k; req_addr = a; req_wdata = wd;
        req_awidth = aw; req_page = pg;
        @(negedge clk);
        req_valid = 0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 ale", ale, 0);
        chk("R1 strobes", {psen_n, rd_n, wr_n}, 3'b111);
        chk("R1 lo_latch", lo_latch, 8'hFF);
        chk("R1 hi_latch", hi_latch, 8'hFF);
        chk("R1 rsp_rdata", rsp_rdata, 0);
        chk("R1 ahi_out", ahi_out, 0);
        rst = 0;
        // R10: software latch writes
        @(negedge clk);
        sw_lo_we = 1; sw_lo_wdata = 8'h3C; sw_hi_we = 1; sw_hi_wdata = 8'h5A;
        @(negedge clk);
        sw_lo_we = 0; sw_hi_we = 0;
        @(negedge clk);
        chk("R10 lo pins", lo_out, 8'h3C);
        chk("R10 hi pins", hi_out, 8'h5A);
        // nonpage, R5/R7/R8
        cfg_xaddr = 2'b00; cfg_rdsel = 2'b00;
        issue(2'b00, 18'h3_1234, 8'h00, 2'b11, 0);          // fetch 16-bit
        chk("R3 lo after fetch", lo_latch, 8'hFF);
        chk("R4 hi after fetch", hi_latch, 8'h5A);
        cfg_rdsel = 2'b01;
        issue(2'b01, 18'h2_ABCD, 8'h00, 2'b11, 0);          // read via rd_n, 18-bit
        cfg_rdsel = 2'b00;
        issue(2'b11, 18'h1_4321, 8'h00, 2'b10, 0);          // read via psen_n, 17-bit
        issue(2'b10, 18'h3_FF77, 8'hC3, 2'b00, 0);          // write, 8-bit
        issue(2'b10, 18'h0_5566, 8'h99, 2'b01, 0);          // write, 16-bit
        // page mode, R6
        cfg_xaddr = 2'b01; cfg_rdsel = 2'b10;
        issue(2'b00, 18'h3_8899, 8'h00, 2'b00, 1);          // fetch 17-bit
        issue(2'b01, 18'h2_1357, 8'h00, 2'b01, 1);          // read 16-bit
        issue(2'b10, 18'h3_2468, 8'hE1, 2'b10, 1);          // write 17-bit
        cfg_xaddr = 2'b11;
        issue(2'b00, 18'h3_0F0F, 8'h00, 2'b00, 1);          // fetch 18-bit
        // R2: request while busy is ignored
        @(negedge clk);
        req_valid = 1; req_kind = 2'b01; req_addr = 18'h0_1111; req_awidth = 2'b01; req_page = 0;
        @(negedge clk);
        req_valid = 1; req_kind = 2'b10; req_addr = 18'h3_EEEE; req_wdata = 8'h42;
        @(negedge clk);
        req_valid = 0;
        wait_idle();
        chk("R2 ignored request", wr_n, 1);
        // R3: low latch write in accept cycle loses
        @(negedge clk);
        sw_lo_we = 1; sw_lo_wdata = 8'h12;
        req_valid = 1; req_kind = 2'b00; req_addr = 18'h0_0202; req_page = 0;
        @(negedge clk);
        sw_lo_we = 0; req_valid = 0;
        chk("R3 clobber wins", lo_latch, 8'hFF);
        wait_idle();
        // R4/R10: high latch write mid-cycle, 8-bit page read
        @(negedge clk);
        req_valid = 1; req_kind = 2'b01; req_addr = 18'h0_00A5; req_awidth = 2'b00; req_page = 1;
        @(negedge clk);
        req_valid = 0; sw_hi_we = 1; sw_hi_wdata = 8'h6B;
        @(negedge clk);
        sw_hi_we = 0;
        wait_idle();
        // nonpage 8-bit read with high latch change during strobe
        @(negedge clk);
        req_valid = 1; req_kind = 2'b01; req_addr = 18'h0_00C7; req_awidth = 2'b00; req_page = 0;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        sw_hi_we = 1; sw_hi_wdata = 8'h81;
        @(negedge clk);
        sw_hi_we = 0;
        wait_idle();
        chk("R4 hi pins after", hi_out, 8'h81);
        // back-to-back requests with valid held
        @(negedge clk);
        req_valid = 1; req_kind = 2'b10; req_addr = 18'h1_2345; req_wdata = 8'h5C; req_awidth = 2'b11; req_page = 0;
        repeat (10) @(negedge clk);
        req_valid = 0;
        wait_idle();
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=busy expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule